// File: doc/BRIEF.md
# Periodic / One-Shot Comparator Channel

One match channel that watches a shared free-running main counter and pulses
`fire_o` for one cycle when its comparator is reached. The counter itself, bus
decoding and interrupt routing live elsewhere. The channel only sees the counter
value and a flag that says the counter is running. Software-side logic drives
three write strobes: one for a 3-bit configuration word and one each for the low
and high 32-bit halves of the comparator. The comparator, the stored period and
the configuration are always visible on readback ports.

In one-shot mode the channel fires once per arming. In periodic mode a match also
starts a catch-up walk: the period is added to the comparator, one addition per
clock, until the comparator is ahead of the counter again, so missed matches
after a counter jump cost no extra pulses. A narrow mode runs the channel on the
low 32 bits of a 64-bit counter. In narrow one-shot mode it also fires once when
the low half of the counter wraps. There is no streaming data path, so all pins
are plain control and status. A configuration write issued in the same cycle as
a comparator write is dropped.

Top module: `cmp_channel`

## Requirements
- R1: After reset the comparator reads all ones, the period reads zero, the configuration reads zero, and `fire_o` is low. The configuration encoding is bit0 periodic, bit1 narrow (32-bit) and bit2 set-value.
- R2: In one-shot mode a comparator write loads the written half of the comparator and arms the channel. `fire_o` is high for exactly one cycle, in the cycle after the clock edge at which the running counter is no longer behind the comparator. The channel then stays silent until it is armed again.
- R3: While `count_run_i` is low the channel never fires, even when the comparator has been passed.
- R4: A configuration write with the narrow bit set clears the upper halves of both the comparator and the period. In narrow mode a high-half comparator write changes neither, and matches look only at the low 32 bits of the counter.
- R5: In periodic mode a low-half write always loads the period. It loads the comparator only when set-value is 1. Set-value reads back as 0 after any comparator write.
- R6: In periodic mode a high-half write with set-value at 0 updates only the upper half of the period and leaves the comparator unchanged.
- R7: Before a value is stored as period, its top bit is cleared: bit 31 of the low half in narrow mode, bit 63 in wide mode.
- R8: A periodic match with a non-zero period fires once. After that the period is added to the comparator once per cycle, with no further fire, until the comparator is ahead of the counter. In narrow mode the sums wrap modulo 2^32.
- R9: The comparator counts as ahead when (comparator minus counter) is non-zero and positive as a signed number of the active width. A counter far above the comparator in unsigned terms can still be behind it.
- R10: In narrow one-shot mode, while armed, the channel also fires once when the low 32 bits of the running counter wrap. This happens at most once per arming.
- R11: Any comparator write re-arms the channel, cancels a catch-up in progress and re-enables the wrap event. A re-armed comparator that is already behind the counter fires on the next running cycle.
- R12: In periodic mode a zero period behaves as one-shot: the channel fires once, does not reload, and keeps its comparator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| count_i | input | 64 | Main counter value |
| count_run_i | input | 1 | Main counter is running |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_wdata_i | input | 3 | Configuration data (bit0 periodic, bit1 narrow, bit2 set-value) |
| cmp_lo_we_i | input | 1 | Low comparator half write strobe |
| cmp_hi_we_i | input | 1 | High comparator half write strobe |
| cmp_wdata_i | input | 32 | Comparator write data |
| fire_o | output | 1 | One-cycle match or wrap event |
| cmp_o | output | 64 | Comparator readback |
| period_o | output | 64 | Stored period readback |
| cfg_o | output | 3 | Configuration readback |

## Verification
The bench jumps the counter well past a periodic comparator. A design that fires
once per missed match, or that takes the whole catch-up in a single cycle, shows
a wrong pulse count or a wrong comparator one cycle after the match. It places
the counter on the far side of the sign boundary: an unsigned compare would fire
there too early. It drives a narrow one-shot channel across a low-half wrap twice.
A design that forgets the wrap or repeats it gives a pulse count that does not
match. It also sends periodic writes with and without set-value and with the top
bit set, which exposes swapped comparator/period loading, a missing clamp, and
upper halves that survive the switch to narrow mode.

// File: rtl/cmpch_pkg.sv
package cmpch_pkg;
  // Packed so that bit0 = periodic, bit1 = narrow, bit2 = set-value.
  typedef struct packed {
    logic setval;
    logic narrow;
    logic periodic;
  } chan_cfg_t;
endpackage

// File: rtl/cmpch_ahead.sv
module cmpch_ahead #(
  parameter int CNT_W = 64,
  localparam int HALF_W = CNT_W / 2
) (
  input  logic [CNT_W-1:0] cmp_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic             narrow_i,
  output logic             ahead_o
);
  logic [CNT_W-1:0]  diff_wide;
  logic [HALF_W-1:0] diff_narrow;

  always_comb begin
    diff_wide   = cmp_i - count_i;
    diff_narrow = cmp_i[HALF_W-1:0] - count_i[HALF_W-1:0];
    if (narrow_i) ahead_o = (diff_narrow != '0) && !diff_narrow[HALF_W-1];
    else          ahead_o = (diff_wide != '0) && !diff_wide[CNT_W-1];
  end
endmodule

// File: rtl/cmpch_wrap.sv
module cmpch_wrap #(
  parameter int HALF_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [HALF_W-1:0] count_lo_i,
  input  logic              run_i,
  output logic              wrap_o
);
  logic [HALF_W-1:0] prev_lo_q;
  logic              prev_run_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_lo_q  <= '0;
      prev_run_q <= 1'b0;
    end else begin
      prev_lo_q  <= count_lo_i;
      prev_run_q <= run_i;
    end
  end

  // A carry out of the low half shows as the low half going down.
  assign wrap_o = run_i && prev_run_q && (count_lo_i < prev_lo_q);
endmodule

// File: rtl/cmpch_regs.sv
module cmpch_regs
  import cmpch_pkg::*;
#(
  parameter int CNT_W = 64,
  localparam int HALF_W = CNT_W / 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we_i,
  input  chan_cfg_t         cfg_wdata_i,
  input  logic              lo_we_i,
  input  logic              hi_we_i,
  input  logic [HALF_W-1:0] wdata_i,
  input  logic              step_i,
  output chan_cfg_t         cfg_o,
  output logic [CNT_W-1:0]  cmp_o,
  output logic [CNT_W-1:0]  period_o
);
  chan_cfg_t         cfg_q;
  logic [CNT_W-1:0]  cmp_q;
  logic [CNT_W-1:0]  period_q;
  logic [HALF_W-1:0] clamped;
  logic [CNT_W-1:0]  sum_wide;
  logic [HALF_W-1:0] sum_narrow;
  logic              load_cmp;

  always_comb begin
    clamped    = {1'b0, wdata_i[HALF_W-2:0]};
    sum_wide   = cmp_q + period_q;
    sum_narrow = cmp_q[HALF_W-1:0] + period_q[HALF_W-1:0];
    load_cmp   = !cfg_q.periodic || cfg_q.setval;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q    <= '0;
      cmp_q    <= '1;
      period_q <= '0;
    end else if (lo_we_i || hi_we_i) begin
      cfg_q.setval <= 1'b0;
      if (lo_we_i) begin
        if (load_cmp) cmp_q[HALF_W-1:0] <= wdata_i;
        if (cfg_q.periodic)
          period_q[HALF_W-1:0] <= cfg_q.narrow ? clamped : wdata_i;
      end
      if (hi_we_i && !cfg_q.narrow) begin
        if (load_cmp) cmp_q[CNT_W-1:HALF_W] <= wdata_i;
        else          period_q[CNT_W-1:HALF_W] <= clamped;
      end
    end else if (cfg_we_i) begin
      cfg_q <= cfg_wdata_i;
      if (cfg_wdata_i.narrow) begin
        cmp_q[CNT_W-1:HALF_W]    <= '0;
        period_q[CNT_W-1:HALF_W] <= '0;
      end
    end else if (step_i) begin
      cmp_q <= cfg_q.narrow ? {{HALF_W{1'b0}}, sum_narrow} : sum_wide;
    end
  end

  assign cfg_o    = cfg_q;
  assign cmp_o    = cmp_q;
  assign period_o = period_q;

  // R4: selecting narrow mode leaves no upper bits behind
  a_r4_narrow_clears_upper: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we_i && !lo_we_i && !hi_we_i && cfg_wdata_i.narrow)
      |=> (cmp_o[CNT_W-1:HALF_W] == '0) && (period_o[CNT_W-1:HALF_W] == '0));

  // R5: set-value never survives a comparator write
  a_r5_setval_self_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_we_i || hi_we_i) |=> !cfg_o.setval);

  // R7: narrow periodic low write stores a clamped period
  a_r7_period_clamp: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_we_i && cfg_o.periodic && cfg_o.narrow) |=> !period_o[HALF_W-1]);
endmodule

// File: rtl/cmpch_ctrl.sv
module cmpch_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic ahead_i,
  input  logic wrap_i,
  input  logic periodic_i,
  input  logic narrow_i,
  input  logic period_nz_i,
  input  logic rearm_i,
  output logic step_o,
  output logic fire_o
);
  logic armed_q;
  logic catching_q;
  logic wrap_armed_q;
  logic fire_q;
  logic match;
  logic reload;
  logic wrap_ev;

  always_comb begin
    match   = armed_q && run_i && !catching_q && !ahead_i;
    reload  = match && periodic_i && period_nz_i;
    wrap_ev = wrap_armed_q && armed_q && !catching_q && narrow_i && !periodic_i && wrap_i;
    step_o  = reload || (catching_q && !ahead_i);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed_q      <= 1'b0;
      catching_q   <= 1'b0;
      wrap_armed_q <= 1'b0;
      fire_q       <= 1'b0;
    end else if (rearm_i) begin
      armed_q      <= 1'b1;
      catching_q   <= 1'b0;
      wrap_armed_q <= 1'b1;
      fire_q       <= 1'b0;
    end else begin
      fire_q <= match || wrap_ev;
      if (match && !reload) begin
        armed_q      <= 1'b0;
        wrap_armed_q <= 1'b0;
      end
      if (reload)                      catching_q <= 1'b1;
      else if (catching_q && ahead_i)  catching_q <= 1'b0;
      if (wrap_ev)                     wrap_armed_q <= 1'b0;
    end
  end

  assign fire_o = fire_q;

  // R3: every pulse comes from a cycle with the counter running
  a_r3_fire_needs_run: assert property (@(posedge clk) disable iff (!rst_n)
    fire_o |-> $past(run_i));

  // R8: no pulse once the catch-up walk is under way
  a_r8_quiet_catchup: assert property (@(posedge clk) disable iff (!rst_n)
    (catching_q && $past(catching_q)) |-> !fire_o);
endmodule

// File: rtl/cmp_channel.sv
module cmp_channel
  import cmpch_pkg::*;
#(
  parameter int CNT_W = 64,
  localparam int HALF_W = CNT_W / 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  count_i,
  input  logic              count_run_i,
  input  logic              cfg_we_i,
  input  logic [2:0]        cfg_wdata_i,
  input  logic              cmp_lo_we_i,
  input  logic              cmp_hi_we_i,
  input  logic [HALF_W-1:0] cmp_wdata_i,
  output logic              fire_o,
  output logic [CNT_W-1:0]  cmp_o,
  output logic [CNT_W-1:0]  period_o,
  output logic [2:0]        cfg_o
);
  chan_cfg_t cfg;
  logic      ahead;
  logic      wrap_seen;
  logic      step;

  cmpch_regs #(.CNT_W(CNT_W)) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_we_i    (cfg_we_i),
    .cfg_wdata_i (chan_cfg_t'(cfg_wdata_i)),
    .lo_we_i     (cmp_lo_we_i),
    .hi_we_i     (cmp_hi_we_i),
    .wdata_i     (cmp_wdata_i),
    .step_i      (step),
    .cfg_o       (cfg),
    .cmp_o       (cmp_o),
    .period_o    (period_o)
  );

  cmpch_ahead #(.CNT_W(CNT_W)) u_ahead (
    .cmp_i    (cmp_o),
    .count_i  (count_i),
    .narrow_i (cfg.narrow),
    .ahead_o  (ahead)
  );

  cmpch_wrap #(.HALF_W(HALF_W)) u_wrap (
    .clk        (clk),
    .rst_n      (rst_n),
    .count_lo_i (count_i[HALF_W-1:0]),
    .run_i      (count_run_i),
    .wrap_o     (wrap_seen)
  );

  cmpch_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .run_i       (count_run_i),
    .ahead_i     (ahead),
    .wrap_i      (wrap_seen),
    .periodic_i  (cfg.periodic),
    .narrow_i    (cfg.narrow),
    .period_nz_i (period_o != '0),
    .rearm_i     (cmp_lo_we_i || cmp_hi_we_i),
    .step_o      (step),
    .fire_o      (fire_o)
  );

  assign cfg_o = cfg;
endmodule

// File: tb/cmp_channel_tb.sv
`timescale 1ns/1ps
module cmp_channel_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] count_i = '0;
  logic        count_run_i = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [2:0]  cfg_wdata_i = '0;
  logic        cmp_lo_we_i = 1'b0;
  logic        cmp_hi_we_i = 1'b0;
  logic [31:0] cmp_wdata_i = '0;
  logic        fire_o;
  logic [63:0] cmp_o;
  logic [63:0] period_o;
  logic [2:0]  cfg_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  cmp_channel u_dut (
    .clk(clk), .rst_n(rst_n), .count_i(count_i), .count_run_i(count_run_i),
    .cfg_we_i(cfg_we_i), .cfg_wdata_i(cfg_wdata_i), .cmp_lo_we_i(cmp_lo_we_i),
    .cmp_hi_we_i(cmp_hi_we_i), .cmp_wdata_i(cmp_wdata_i), .fire_o(fire_o),
    .cmp_o(cmp_o), .period_o(period_o), .cfg_o(cfg_o)
  );

  always #2.5 clk = ~clk;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // All tasks enter and leave at a falling edge.
  task automatic do_reset();
    rst_n = 1'b0; count_run_i = 1'b0; count_i = '0;
    cfg_we_i = 1'b0; cmp_lo_we_i = 1'b0; cmp_hi_we_i = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr_cfg(input logic [2:0] v);
    count_run_i = 1'b0; cfg_we_i = 1'b1; cfg_wdata_i = v;
    @(posedge clk); @(negedge clk);
    cfg_we_i = 1'b0;
  endtask

  task automatic wr_lo(input logic [31:0] v);
    count_run_i = 1'b0; cmp_lo_we_i = 1'b1; cmp_wdata_i = v;
    @(posedge clk); @(negedge clk);
    cmp_lo_we_i = 1'b0;
  endtask

  task automatic wr_hi(input logic [31:0] v);
    count_run_i = 1'b0; cmp_hi_we_i = 1'b1; cmp_wdata_i = v;
    @(posedge clk); @(negedge clk);
    cmp_hi_we_i = 1'b0;
  endtask

  task automatic step(input logic [63:0] c, input logic r, output logic f);
    count_i = c; count_run_i = r;
    @(posedge clk); @(negedge clk);
    f = fire_o;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 cmp", cmp_o, '1);
    chk("R1 period", period_o, '0);
    chk("R1 cfg", {61'b0, cfg_o}, '0);
    chk("R1 fire", {63'b0, fire_o}, '0);
  endtask

  task automatic t_oneshot();
    logic f;
    do_reset();
    wr_hi(32'h1); wr_lo(32'h10);
    chk("R2 cmp load", cmp_o, 64'h1_0000_0010);
    step(64'h10, 1, f);           chk("R4 upper half counted", {63'b0, f}, 0);
    step(64'h1_0000_000F, 1, f);  chk("R2 before match", {63'b0, f}, 0);
    step(64'h1_0000_0010, 1, f);  chk("R2 match fire", {63'b0, f}, 1);
    step(64'h1_0000_0011, 1, f);  chk("R2 single pulse", {63'b0, f}, 0);
    step(64'h1_0000_0050, 1, f);  chk("R2 stays disarmed", {63'b0, f}, 0);
  endtask

  task automatic t_sign();
    logic f;
    do_reset();
    wr_hi(32'h0); wr_lo(32'h10);
    step(64'h8000_0000_0000_0011, 1, f); chk("R9 far counter is behind", {63'b0, f}, 0);
    step(64'h11, 1, f);                  chk("R9 passed comparator", {63'b0, f}, 1);
  endtask

  task automatic t_run_rearm();
    logic f;
    do_reset();
    wr_hi(32'h0); wr_lo(32'h10);
    step(64'h40, 0, f); chk("R3 stopped no fire", {63'b0, f}, 0);
    step(64'h40, 0, f); chk("R3 stopped no fire 2", {63'b0, f}, 0);
    step(64'h40, 1, f); chk("R3 fire once running", {63'b0, f}, 1);
    step(64'h41, 1, f); chk("R11 quiet before rearm", {63'b0, f}, 0);
    wr_lo(32'h50);
    step(64'h50, 1, f); chk("R11 rearm fires", {63'b0, f}, 1);
    wr_lo(32'h10);
    step(64'h60, 1, f); chk("R11 behind fires at once", {63'b0, f}, 1);
  endtask

  task automatic t_regs();
    do_reset();
    wr_cfg(3'b001);
    wr_lo(32'h50);
    chk("R5 no setval cmp kept", cmp_o, '1);
    chk("R5 period loaded", period_o, 64'h50);
    wr_cfg(3'b101);
    chk("R5 setval readback", {61'b0, cfg_o}, 64'h5);
    wr_lo(32'h60);
    chk("R5 setval cmp loaded", cmp_o, 64'hFFFF_FFFF_0000_0060);
    chk("R5 setval period loaded", period_o, 64'h60);
    chk("R5 setval cleared", {61'b0, cfg_o}, 64'h1);
    wr_hi(32'h3);
    chk("R6 hi period only", period_o, 64'h3_0000_0060);
    chk("R6 cmp untouched", cmp_o, 64'hFFFF_FFFF_0000_0060);
    wr_hi(32'hFFFF_FFFF);
    chk("R7 wide clamp", period_o, 64'h7FFF_FFFF_0000_0060);
    wr_cfg(3'b011);
    chk("R4 cmp upper cleared", cmp_o, 64'h60);
    chk("R4 period upper cleared", period_o, 64'h60);
    wr_lo(32'hFFFF_FFFF);
    chk("R7 narrow clamp", period_o, 64'h7FFF_FFFF);
    wr_hi(32'h5);
    chk("R4 narrow hi ignored period", period_o, 64'h7FFF_FFFF);
    wr_cfg(3'b010);
    wr_hi(32'h9);
    chk("R4 narrow hi ignored cmp", cmp_o, 64'h60);
  endtask

  task automatic t_catchup();
    logic f;
    int extra;
    do_reset();
    wr_cfg(3'b101); wr_hi(32'h0);
    wr_cfg(3'b101); wr_lo(32'd100);
    chk("R8 setup period", period_o, 64'd100);
    step(64'd1050, 1, f);
    chk("R8 fire on match", {63'b0, f}, 1);
    chk("R8 one step per cycle", cmp_o, 64'd200);
    extra = 0;
    for (int i = 0; i < 15; i++) begin
      step(64'd1050, 1, f);
      if (f) extra++;
    end
    chk("R8 no fire during catch-up", 64'(extra), 0);
    chk("R8 comparator ahead", cmp_o, 64'd1100);
    step(64'd1100, 1, f);
    chk("R8 next period fires", {63'b0, f}, 1);
  endtask

  task automatic t_narrow_periodic();
    logic f;
    do_reset();
    wr_cfg(3'b111);
    wr_lo(32'hFFFF_FFF0);
    chk("R7 clamped period", period_o, 64'h7FFF_FFF0);
    step(64'h1_FFFF_FFF0, 1, f);
    chk("R8 narrow fire", {63'b0, f}, 1);
    chk("R8 narrow sum wraps", cmp_o, 64'h7FFF_FFE0);
    step(64'h1_FFFF_FFF0, 1, f);
    chk("R8 narrow settled", {63'b0, f}, 0);
    chk("R8 narrow cmp held", cmp_o, 64'h7FFF_FFE0);
  endtask

  task automatic t_wrap();
    logic f;
    do_reset();
    wr_cfg(3'b010);
    wr_lo(32'h20);
    step(64'hFFFF_FFFE, 1, f);   chk("R10 before wrap", {63'b0, f}, 0);
    step(64'hFFFF_FFFF, 1, f);   chk("R10 at top", {63'b0, f}, 0);
    step(64'h1_0000_0000, 1, f); chk("R10 wrap fire", {63'b0, f}, 1);
    step(64'h1_0000_0001, 1, f); chk("R10 single wrap pulse", {63'b0, f}, 0);
    step(64'h1_0000_0020, 1, f); chk("R10 match after wrap", {63'b0, f}, 1);
    step(64'h1_0000_0021, 1, f); chk("R10 quiet after match", {63'b0, f}, 0);
    step(64'h1_FFFF_FFFF, 1, f);
    step(64'h2_0000_0000, 1, f); chk("R10 no second wrap", {63'b0, f}, 0);
  endtask

  task automatic t_zero_period();
    logic f;
    do_reset();
    wr_cfg(3'b101); wr_hi(32'h0);
    wr_cfg(3'b101); wr_lo(32'h0);
    chk("R12 setup cmp", cmp_o, 64'h0);
    chk("R12 setup period", period_o, 64'h0);
    step(64'd5, 1, f); chk("R12 fires once", {63'b0, f}, 1);
    step(64'd6, 1, f); chk("R12 no reload fire", {63'b0, f}, 0);
    step(64'd7, 1, f); chk("R12 still quiet", {63'b0, f}, 0);
    chk("R12 cmp kept", cmp_o, 64'h0);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_oneshot();
    t_sign();
    t_run_rearm();
    t_regs();
    t_catchup();
    t_narrow_periodic();
    t_wrap();
    t_zero_period();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule